// File: doc/BRIEF.md
# Flash Region Access Guard

This block sits in front of a flash array and decides, for every access, whether it may proceed. Software programs up to `NREG` guarded regions through a narrow configuration port. Each region is a run of whole 1 KB sectors given by a starting sector and a sector count, and it carries one of three protection behaviours. The first denies both data reads and instruction fetches. The second is execute-only: fetches pass and data reads are refused. The third is a data-area mode, in which read blocking and write blocking are set separately.

Each access presents an address, an access kind and the identity of the requester. One clock later the block returns a verdict, a flag telling whether any region covered the address, and the index of the region that decided the verdict. The requester identity never changes the verdict: processor, DMA engine and debug probe are judged by the same rules. A region can be frozen with a lock bit. After that, its settings hold until the next reset.

Top module: `flash_guard`

## Requirements
- R1: Region i covers an access when its mode is not off and base*1024 <= address < (base+size)*1024, with base and size counted in 1 KB sectors; a size of zero covers nothing.
- R2: Mode code 1 (no read, no fetch) denies fetches (type code 0) and data reads (type code 1) and allows writes (type code 2).
- R3: Mode code 2 (execute-only) denies data reads and allows fetches and writes.
- R4: Mode code 3 (data area) denies reads and fetches when the region's read-block bit is set, and denies writes when its write-block bit is set; the two bits act independently.
- R5: The requester code (0 processor, 1 DMA, 2 debug) has no effect on the verdict and is returned unchanged on rsp_req.
- R6: A configuration write replaces all fields of region cfg_idx and loads its lock bit from cfg_lock; while a region's lock bit is set, writes to it are ignored until reset.
- R7: An access that no region covers is allowed, with rsp_hit at 0 and rsp_region at 0.
- R8: When several regions cover an access, it is denied if any of them denies it, and rsp_region then names the lowest-numbered denying region; when none of them denies it, rsp_region names the lowest-numbered covering region.
- R9: The response appears on the clock edge after acc_valid is sampled high, and rsp_valid is 0 in every cycle that follows a cycle without acc_valid.
- R10: After reset every region is off and unlocked, and rsp_valid is 0.
- R11: Access type code 3 is treated as a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Region being written |
| cfg_base | input | SIDX_W | First sector of the region |
| cfg_size | input | SIDX_W+1 | Number of sectors in the region |
| cfg_mode | input | 2 | 0 off, 1 no read/fetch, 2 execute-only, 3 data area |
| cfg_blk_rd | input | 1 | Data-area read block |
| cfg_blk_wr | input | 1 | Data-area write block |
| cfg_lock | input | 1 | Freeze this region after the write |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_type | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| acc_req | input | 2 | Requester: 0 processor, 1 DMA, 2 debug |
| rsp_valid | output | 1 | Verdict is present |
| rsp_deny | output | 1 | Access refused |
| rsp_hit | output | 1 | At least one region covered the access |
| rsp_region | output | IDX_W | Region that decided the verdict |
| rsp_req | output | 2 | Requester of the answered access |

## Verification
The assertions assume that acc_valid, acc_type and acc_req are driven to known values in every cycle after reset. They also assume that configuration writes and accesses are both applied synchronously, so a write that lands in the same cycle as an access applies to the following access. The bench drives all inputs on the falling edge, holds cfg_we to a single cycle, and reads each response on the falling edge after the request edge. It lays out overlapping regions so that every pairing of a denying and an allowing region is reached. It also retries writes to locked regions before it resets the block.

// File: rtl/fg_pkg.sv
package fg_pkg;
  // protection behaviours of a region
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_NORX = 2'd1;
  localparam logic [1:0] MODE_XO   = 2'd2;
  localparam logic [1:0] MODE_DATA = 2'd3;

  // kinds of access
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_READ  = 2'd1;
  localparam logic [1:0] ACC_WRITE = 2'd2;
  localparam logic [1:0] ACC_RSVD  = 2'd3;

  // requesters
  localparam logic [1:0] REQ_CPU = 2'd0;
  localparam logic [1:0] REQ_DMA = 2'd1;
  localparam logic [1:0] REQ_DBG = 2'd2;
endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/fg_regbank.sv
module fg_regbank #(
  parameter int NREG   = 8,
  parameter int IDX_W  = 3,
  parameter int SIDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SIDX_W-1:0] cfg_base,
  input  logic [SIDX_W:0]   cfg_size,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_blk_rd,
  input  logic              cfg_blk_wr,
  input  logic              cfg_lock,
  output logic [SIDX_W-1:0] base_o   [NREG],
  output logic [SIDX_W:0]   size_o   [NREG],
  output logic [1:0]        mode_o   [NREG],
  output logic              blk_rd_o [NREG],
  output logic              blk_wr_o [NREG]
);
  import fg_pkg::*;

  logic [SIDX_W-1:0] base_q [NREG];
  logic [SIDX_W:0]   size_q [NREG];
  logic [1:0]        mode_q [NREG];
  logic              brd_q  [NREG];
  logic              bwr_q  [NREG];
  logic              lock_q [NREG];
  logic              wen    [NREG];

  // per-region write enable: addressed and not frozen
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wen[i] = cfg_we && (cfg_idx == IDX_W'(i)) && !lock_q[i];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
        mode_q[g] <= MODE_OFF;
        brd_q[g]  <= 1'b0;
        bwr_q[g]  <= 1'b0;
        lock_q[g] <= 1'b0;
      end else if (wen[g]) begin
        base_q[g] <= cfg_base;
        size_q[g] <= cfg_size;
        mode_q[g] <= cfg_mode;
        brd_q[g]  <= cfg_blk_rd;
        bwr_q[g]  <= cfg_blk_wr;
        lock_q[g] <= cfg_lock;
      end
    end

    assign base_o[g]   = base_q[g];
    assign size_o[g]   = size_q[g];
    assign mode_o[g]   = mode_q[g];
    assign blk_rd_o[g] = brd_q[g];
    assign blk_wr_o[g] = bwr_q[g];

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g] |=> lock_q[g] && $stable(base_q[g]) && $stable(size_q[g]) &&
                    $stable(mode_q[g]) && $stable(brd_q[g]) && $stable(bwr_q[g])); // R6
  end
endmodule

// File: rtl/fg_match.sv
module fg_match #(
  parameter int NREG       = 8,
  parameter int ADDR_W     = 20,
  parameter int SECT_SHIFT = 10,
  parameter int SIDX_W     = ADDR_W - SECT_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_type,
  input  logic [SIDX_W-1:0] base_i   [NREG],
  input  logic [SIDX_W:0]   size_i   [NREG],
  input  logic [1:0]        mode_i   [NREG],
  input  logic              blk_rd_i [NREG],
  input  logic              blk_wr_i [NREG],
  output logic [NREG-1:0]   hit,
  output logic [NREG-1:0]   deny
);
  import fg_pkg::*;

  localparam int CMP_W = ADDR_W + 1;

  logic is_wr, is_fetch, is_rd;
  assign is_wr    = (acc_type == ACC_WRITE);
  assign is_fetch = (acc_type == ACC_FETCH);
  assign is_rd    = !is_wr && !is_fetch;   // read and reserved code

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [CMP_W-1:0] lo, hi, a_ext;
    assign a_ext = {1'b0, addr};
    assign lo    = CMP_W'(base_i[g]) << SECT_SHIFT;
    assign hi    = (CMP_W'(base_i[g]) + CMP_W'(size_i[g])) << SECT_SHIFT;

    always_comb begin
      hit[g] = (mode_i[g] != MODE_OFF) && (a_ext >= lo) && (a_ext < hi);
      unique case (mode_i[g])
        MODE_NORX: deny[g] = !is_wr;
        MODE_XO:   deny[g] = is_rd;
        MODE_DATA: deny[g] = is_wr ? blk_wr_i[g] : blk_rd_i[g];
        default:   deny[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fg_resolve.sv
module fg_resolve #(
  parameter int NREG  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NREG-1:0]  hit,
  input  logic [NREG-1:0]  deny,
  output logic             any_hit,
  output logic             any_deny,
  output logic [IDX_W-1:0] region
);
  logic [IDX_W-1:0] hit_idx, deny_idx;

  // descending scan: the last assignment is the lowest index
  always_comb begin
    any_hit  = 1'b0;
    any_deny = 1'b0;
    hit_idx  = '0;
    deny_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
        if (deny[i]) begin
          any_deny = 1'b1;
          deny_idx = IDX_W'(i);
        end
      end
    end
    region = any_deny ? deny_idx : hit_idx;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int NREG       = 8,
  parameter int ADDR_W     = 20,
  parameter int SECT_SHIFT = 10,
  localparam int IDX_W     = $clog2(NREG),
  localparam int SIDX_W    = ADDR_W - SECT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SIDX_W-1:0] cfg_base,
  input  logic [SIDX_W:0]   cfg_size,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_blk_rd,
  input  logic              cfg_blk_wr,
  input  logic              cfg_lock,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_type,
  input  logic [1:0]        acc_req,
  output logic              rsp_valid,
  output logic              rsp_deny,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region,
  output logic [1:0]        rsp_req
);
  logic rst_ns;

  logic [SIDX_W-1:0] base_w  [NREG];
  logic [SIDX_W:0]   size_w  [NREG];
  logic [1:0]        mode_w  [NREG];
  logic              brd_w   [NREG];
  logic              bwr_w   [NREG];
  logic [NREG-1:0]   hit_w, deny_w;
  logic              any_hit, any_deny;
  logic [IDX_W-1:0]  region_w;

  logic             vld_q, vld_d;
  logic             deny_q, deny_d;
  logic             hitf_q, hitf_d;
  logic [IDX_W-1:0] rgn_q, rgn_d;
  logic [1:0]       req_q, req_d;
  logic             rsp_en;

  fg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  fg_regbank #(.NREG(NREG), .IDX_W(IDX_W), .SIDX_W(SIDX_W)) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_mode(cfg_mode), .cfg_blk_rd(cfg_blk_rd), .cfg_blk_wr(cfg_blk_wr),
    .cfg_lock(cfg_lock),
    .base_o(base_w), .size_o(size_w), .mode_o(mode_w),
    .blk_rd_o(brd_w), .blk_wr_o(bwr_w)
  );

  fg_match #(.NREG(NREG), .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .SIDX_W(SIDX_W)) u_match (
    .addr(acc_addr), .acc_type(acc_type),
    .base_i(base_w), .size_i(size_w), .mode_i(mode_w),
    .blk_rd_i(brd_w), .blk_wr_i(bwr_w),
    .hit(hit_w), .deny(deny_w)
  );

  fg_resolve #(.NREG(NREG), .IDX_W(IDX_W)) u_res (
    .hit(hit_w), .deny(deny_w),
    .any_hit(any_hit), .any_deny(any_deny), .region(region_w)
  );

  // next state: payload captured only when a request is present
  assign rsp_en = acc_valid;

  always_comb begin
    vld_d  = acc_valid;
    deny_d = deny_q;
    hitf_d = hitf_q;
    rgn_d  = rgn_q;
    req_d  = req_q;
    if (rsp_en) begin
      deny_d = any_deny;
      hitf_d = any_hit;
      rgn_d  = region_w;
      req_d  = acc_req;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q  <= 1'b0;
      deny_q <= 1'b0;
      hitf_q <= 1'b0;
      rgn_q  <= '0;
      req_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      deny_q <= deny_d;
      hitf_q <= hitf_d;
      rgn_q  <= rgn_d;
      req_q  <= req_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_deny   = deny_q;
  assign rsp_hit    = hitf_q;
  assign rsp_region = rgn_q;
  assign rsp_req    = req_q;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_ns)
    acc_valid |=> rsp_valid); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_ns)
    !acc_valid |=> !rsp_valid); // R9
  AST_MISS_ALLOWS: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && !rsp_hit) |-> (!rsp_deny && rsp_region == '0)); // R7
  AST_REQ_ECHO: assert property (@(posedge clk) disable iff (!rst_ns)
    acc_valid |=> (rsp_req == $past(acc_req))); // R5
  AST_DENY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && rsp_deny) |-> rsp_hit); // R8
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  import fg_pkg::*;

  localparam int NREG = 8, ADDR_W = 20, SECT_SHIFT = 10;
  localparam int IDX_W = $clog2(NREG), SIDX_W = ADDR_W - SECT_SHIFT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_blk_rd = 1'b0, cfg_blk_wr = 1'b0, cfg_lock = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [SIDX_W-1:0] cfg_base = '0;
  logic [SIDX_W:0] cfg_size = '0;
  logic [1:0] cfg_mode = '0, acc_type = '0, acc_req = '0;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic rsp_valid, rsp_deny, rsp_hit;
  logic [IDX_W-1:0] rsp_region;
  logic [1:0] rsp_req;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  flash_guard #(.NREG(NREG), .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT)) u0 (.*);

  task automatic cfg_write(input int idx, input int base, input int size,
                           input logic [1:0] mode, input bit brd, input bit bwr, input bit lck);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_base = SIDX_W'(base);
    cfg_size = (SIDX_W+1)'(size); cfg_mode = mode;
    cfg_blk_rd = brd; cfg_blk_wr = bwr; cfg_lock = lck;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input int addr, input logic [1:0] typ, input logic [1:0] req,
                        input bit e_deny, input bit e_hit, input int e_idx, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = ADDR_W'(addr); acc_type = typ; acc_req = req;
    @(negedge clk);
    acc_valid = 1'b0;
    checks++;
    if (!rsp_valid || rsp_deny !== e_deny || rsp_hit !== e_hit ||
        rsp_region !== IDX_W'(e_idx) || rsp_req !== req) begin
      errors++;
      $display("FAIL %s: got valid=%0b deny=%0b hit=%0b region=%0d req=%0d exp valid=1 deny=%0b hit=%0b region=%0d req=%0d",
               tag, rsp_valid, rsp_deny, rsp_hit, rsp_region, rsp_req, e_deny, e_hit, e_idx, req);
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: got rsp_valid=%0b exp 0", tag, rsp_valid);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check_idle("R10 reset rsp_valid");
    access(4096, ACC_READ, REQ_CPU, 0, 0, 0, "R10 no region after reset");
    access(0, ACC_FETCH, REQ_CPU, 0, 0, 0, "R7 miss allowed");
  endtask

  task automatic t_bounds();
    cfg_write(0, 4, 2, MODE_NORX, 0, 0, 0);
    access(4*1024-1, ACC_READ, REQ_CPU, 0, 0, 0, "R1 below base");
    access(4*1024,   ACC_READ, REQ_CPU, 1, 1, 0, "R1 first byte");
    access(6*1024-1, ACC_FETCH, REQ_CPU, 1, 1, 0, "R1 last byte");
    access(6*1024,   ACC_READ, REQ_CPU, 0, 0, 0, "R1 past end");
    access(4*1024+8, ACC_WRITE, REQ_CPU, 0, 1, 0, "R2 write allowed");
    access(5*1024,   ACC_RSVD, REQ_CPU, 1, 1, 0, "R11 code 3 as read");
    cfg_write(6, 40, 0, MODE_NORX, 0, 0, 0);
    access(40*1024,  ACC_READ, REQ_CPU, 0, 0, 0, "R1 zero size");
  endtask

  task automatic t_xo();
    cfg_write(1, 10, 1, MODE_XO, 0, 0, 0);
    access(10*1024+4, ACC_FETCH, REQ_CPU, 0, 1, 1, "R3 fetch allowed");
    access(10*1024+4, ACC_READ,  REQ_CPU, 1, 1, 1, "R3 read denied");
    access(10*1024+4, ACC_WRITE, REQ_CPU, 0, 1, 1, "R3 write allowed");
  endtask

  task automatic t_data();
    cfg_write(2, 20, 4, MODE_DATA, 1, 0, 0);
    access(21*1024, ACC_READ,  REQ_CPU, 1, 1, 2, "R4 rd-block read");
    access(21*1024, ACC_FETCH, REQ_CPU, 1, 1, 2, "R4 rd-block fetch");
    access(21*1024, ACC_WRITE, REQ_CPU, 0, 1, 2, "R4 rd-block write");
    cfg_write(2, 20, 4, MODE_DATA, 0, 1, 0);
    access(23*1024, ACC_READ,  REQ_CPU, 0, 1, 2, "R4 wr-block read");
    access(23*1024, ACC_WRITE, REQ_CPU, 1, 1, 2, "R4 wr-block write");
    cfg_write(2, 20, 4, MODE_DATA, 1, 1, 0);
    access(20*1024, ACC_READ,  REQ_CPU, 1, 1, 2, "R4 both read");
    access(20*1024, ACC_WRITE, REQ_CPU, 1, 1, 2, "R4 both write");
    cfg_write(2, 20, 4, MODE_DATA, 0, 0, 0);
    access(20*1024, ACC_WRITE, REQ_CPU, 0, 1, 2, "R4 neither write");
  endtask

  task automatic t_requesters();
    access(4*1024, ACC_READ, REQ_DMA, 1, 1, 0, "R5 dma denied");
    access(4*1024, ACC_READ, REQ_DBG, 1, 1, 0, "R5 debug denied");
    access(10*1024, ACC_FETCH, REQ_DBG, 0, 1, 1, "R5 debug fetch xo");
    access(10*1024, ACC_READ, REQ_DMA, 1, 1, 1, "R5 dma read xo");
  endtask

  task automatic t_overlap();
    cfg_write(3, 30, 8, MODE_XO,   0, 0, 0);
    cfg_write(4, 32, 2, MODE_NORX, 0, 0, 0);
    cfg_write(5, 31, 4, MODE_DATA, 0, 1, 0);
    access(32*1024, ACC_READ,  REQ_CPU, 1, 1, 3, "R8 two deny lowest");
    access(32*1024, ACC_FETCH, REQ_CPU, 1, 1, 4, "R8 higher denies");
    access(32*1024, ACC_WRITE, REQ_CPU, 1, 1, 5, "R8 only top denies");
    access(31*1024, ACC_FETCH, REQ_CPU, 0, 1, 3, "R8 all allow lowest");
    access(30*1024, ACC_WRITE, REQ_CPU, 0, 1, 3, "R8 single allow");
  endtask

  task automatic t_lock();
    cfg_write(1, 10, 1, MODE_XO, 0, 0, 1);
    cfg_write(1, 10, 1, MODE_OFF, 0, 0, 0);
    access(10*1024, ACC_READ, REQ_CPU, 1, 1, 1, "R6 locked rewrite ignored");
    cfg_write(1, 50, 1, MODE_NORX, 0, 0, 0);
    access(50*1024, ACC_READ, REQ_CPU, 0, 0, 0, "R6 locked move ignored");
    cfg_write(0, 4, 2, MODE_OFF, 0, 0, 0);
    access(4*1024, ACC_READ, REQ_CPU, 0, 0, 0, "R6 unlocked rewrite applies");
    do_reset();
    access(10*1024, ACC_READ, REQ_CPU, 0, 0, 0, "R10 lock cleared by reset");
    cfg_write(1, 10, 1, MODE_NORX, 0, 0, 0);
    access(10*1024, ACC_FETCH, REQ_CPU, 1, 1, 1, "R10 region writable after reset");
  endtask

  task automatic t_timing();
    access(10*1024, ACC_READ, REQ_CPU, 1, 1, 1, "R9 one-cycle response");
    check_idle("R9 idle after request");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_bounds();
    t_xo();
    t_data();
    t_requesters();
    t_overlap();
    t_lock();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule